// File: doc/BRIEF.md
# Secure and Privileged Register Access Filter

This block stands between a peripheral bus port and the register file of a clock-calendar unit. Each bus access carries an address, write data, byte enables, a secure attribute and a privilege attribute. The filter looks up the protection group of the addressed register, then works out a per-bit allow mask from two control words that it holds itself: one secure word and one privilege word. A write reaches the register file only on its allowed and byte-enabled bits. A read returns the register file data ANDed with the same mask, so blocked bits read as zero. Blocked accesses never signal a bus error.

An access that breaks secure protection on a whole register gives a one-cycle illegal-access pulse for a security controller. Registers whose bits belong to several functions (the status, flag-clear and masked-status words, and the tamper configuration word) are filtered bit by bit and raise no pulse. The backup registers are whole-register protected. The secure word is cleared only by the backup-domain reset. A system reset clears the pulse and leaves the protection settings as they are. A secure-active output tells the reset and clock controller to treat the timekeeping block's controls as secure.

Top module: `rtc_access_filter`

## Requirements
- R1: After the backup-domain reset both control words are zero and secure_active is low. Every mapped register except the secure word at address 14 can then be read and written by privileged masters, secure or not. Non-secure writes to the secure word are always dropped.
- R2: A non-secure write to a whole register whose function secure bit is set leaves rf_we low. No error is returned.
- R3: A non-secure read of a whole register whose function secure bit is set returns all zeros.
- R4: A non-secure access that is blocked on a whole register pulses illegal_pulse for exactly the following cycle. This covers a function register whose secure bit is set, a backup register while backup-secure is set, and any write to the secure word.
- R5: The status (11), flag-clear (12) and masked-status (13) words are filtered bit by bit: bit f belongs to function f for f in 0..6, and bits 7..31 are unprotected. Writes update only the allowed bits through rf_wmask. Blocked bits read as zero. No pulse is raised.
- R6: In the tamper configuration word (10), bit 31 (auto-clear) follows the backup-secure and backup-privilege bits. The other bits follow the tamper function bits. The word raises no pulse.
- R7: With the global privilege bit at 0, unprivileged reads are served only for the time, date, subsecond, prescaler and calibration registers and the two control words. Other registers read as zero.
- R8: With the global privilege bit at 0, unprivileged writes to any non-backup register are dropped.
- R9: With the global privilege bit at 1, an unprivileged access is blocked exactly on the registers and bits owned by a function whose privilege bit is set. Writes to the control words still need privilege.
- R10: The backup registers (16..23) follow backup-secure (secure word bit 8) for non-secure accesses. They follow backup-privilege (privilege word bit 8) for unprivileged accesses, whatever the global privilege bit holds.
- R11: A system reset alone clears illegal_pulse and keeps both control words and secure_active.
- R12: secure_active is high whenever any function secure bit or the backup-secure bit is set.
- R13: Address map: 0 time, 1 date, 3 prescaler and 5 control belong to init (function 0). 4 calibration is calibration (1), 9 timestamp is timestamp (2), 6 wakeup is wakeup (3), 7 alarm 0 is alarm 0 (4) and 8 alarm 1 is alarm 1 (5). Tamper is function 6. 2 subsecond is unprotected. 14 is the secure word (bits 6:0 functions, bit 8 backup) and 15 is the privilege word (bits 6:0 functions, bit 8 backup, bit 15 global). Unmapped addresses 24..31 read zero and are never written.
- R14: Byte enable k gates bits 8k+7..8k of every write, to the register file and to the control words alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_bkp_n | input | 1 | Backup-domain reset, synchronous, active low |
| rst_sys_n | input | 1 | System reset, synchronous, active low |
| bus_req | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_be | input | DATA_W/8 | Byte enables |
| bus_sec | input | 1 | Access is secure |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | DATA_W | Filtered read data |
| rf_we | output | 1 | Register file write strobe |
| rf_addr | output | ADDR_W | Register file address |
| rf_wdata | output | DATA_W | Register file write data |
| rf_wmask | output | DATA_W | Per-bit write mask |
| rf_rdata | input | DATA_W | Register file read data |
| illegal_pulse | output | 1 | Illegal secure access seen last cycle |
| secure_active | output | 1 | Some function is secure |

## Verification
The bench attacks the partly protected words. A design that gates the whole tamper word on the tamper bit would lose the auto-clear bit, or let it through. A design that raised the pulse on status words would pulse where no pulse is due. It also drives unprivileged backup accesses under both global privilege settings, and an RTL that applied the global rule to backup registers would drop writes it must pass. Runs with system reset alone and then backup reset show whether the protection state sits in the wrong reset domain. Partial byte enables on the control words show whether unenabled fields get overwritten.

// File: rtl/rtc_filt_pkg.sv
package rtc_filt_pkg;
    localparam int unsigned FN_INIT   = 0;
    localparam int unsigned FN_CALIB  = 1;
    localparam int unsigned FN_TSTAMP = 2;
    localparam int unsigned FN_WAKE   = 3;
    localparam int unsigned FN_ALM0   = 4;
    localparam int unsigned FN_ALM1   = 5;
    localparam int unsigned FN_TAMP   = 6;

    localparam int unsigned BKP_BIT    = 8;
    localparam int unsigned GLOBAL_BIT = 15;

    localparam int unsigned A_TIME     = 0;
    localparam int unsigned A_DATE     = 1;
    localparam int unsigned A_SUBSEC   = 2;
    localparam int unsigned A_PRESC    = 3;
    localparam int unsigned A_CALIB    = 4;
    localparam int unsigned A_CTRL     = 5;
    localparam int unsigned A_WAKE     = 6;
    localparam int unsigned A_ALM0     = 7;
    localparam int unsigned A_ALM1     = 8;
    localparam int unsigned A_TSTAMP   = 9;
    localparam int unsigned A_TAMPCFG  = 10;
    localparam int unsigned A_STATUS   = 11;
    localparam int unsigned A_FLAGCLR  = 12;
    localparam int unsigned A_MASKST   = 13;
    localparam int unsigned A_SECCTL   = 14;
    localparam int unsigned A_PRIVCTL  = 15;
    localparam int unsigned A_BKP_BASE = 16;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_OPEN,
        RK_GROUP,
        RK_BITWISE,
        RK_TAMPCFG,
        RK_SECCTL,
        RK_PRIVCTL,
        RK_BKP
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [2:0] fn;
        logic       open_rd;
    } reg_info_t;
endpackage

// File: rtl/rtc_filt_decode.sv
module rtc_filt_decode
    import rtc_filt_pkg::*;
#(
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned NUM_BKP = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_info_t         info
);
    localparam int unsigned BKP_END = A_BKP_BASE + NUM_BKP;

    always_comb begin
        int unsigned a;
        a = 32'(addr);
        info = '{kind: RK_NONE, fn: 3'd0, open_rd: 1'b0};
        if (a >= A_BKP_BASE) begin
            if (a < BKP_END) begin
                info.kind = RK_BKP;
            end
        end else begin
            case (a)
                A_TIME, A_DATE, A_PRESC: begin
                    info.kind    = RK_GROUP;
                    info.fn      = 3'(FN_INIT);
                    info.open_rd = 1'b1;
                end
                A_CTRL: begin
                    info.kind = RK_GROUP;
                    info.fn   = 3'(FN_INIT);
                end
                A_SUBSEC: begin
                    info.kind    = RK_OPEN;
                    info.open_rd = 1'b1;
                end
                A_CALIB: begin
                    info.kind    = RK_GROUP;
                    info.fn      = 3'(FN_CALIB);
                    info.open_rd = 1'b1;
                end
                A_WAKE: begin
                    info.kind = RK_GROUP;
                    info.fn   = 3'(FN_WAKE);
                end
                A_ALM0: begin
                    info.kind = RK_GROUP;
                    info.fn   = 3'(FN_ALM0);
                end
                A_ALM1: begin
                    info.kind = RK_GROUP;
                    info.fn   = 3'(FN_ALM1);
                end
                A_TSTAMP: begin
                    info.kind = RK_GROUP;
                    info.fn   = 3'(FN_TSTAMP);
                end
                A_TAMPCFG: info.kind = RK_TAMPCFG;
                A_STATUS, A_FLAGCLR, A_MASKST: info.kind = RK_BITWISE;
                A_SECCTL: begin
                    info.kind    = RK_SECCTL;
                    info.open_rd = 1'b1;
                end
                A_PRIVCTL: begin
                    info.kind    = RK_PRIVCTL;
                    info.open_rd = 1'b1;
                end
                default: info.kind = RK_NONE;
            endcase
        end
    end
endmodule

// File: rtl/rtc_filt_perm.sv
module rtc_filt_perm
    import rtc_filt_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_FUNC = 7
) (
    input  reg_info_t           info,
    input  logic                wr,
    input  logic                sec,
    input  logic                priv,
    input  logic [NUM_FUNC-1:0] fsec,
    input  logic [NUM_FUNC-1:0] fpriv,
    input  logic                bkp_sec,
    input  logic                bkp_priv,
    input  logic                gpriv,
    output logic [DATA_W-1:0]   sec_ok,
    output logic [DATA_W-1:0]   priv_ok,
    output logic                whole_viol
);
    localparam int unsigned AC_BIT = DATA_W - 1;

    logic [DATA_W-1:0] bw_sec, bw_priv, tc_sec, tc_priv;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b < NUM_FUNC) begin : g_fn
            assign bw_sec[b]  = fsec[b];
            assign bw_priv[b] = fpriv[b];
        end else begin : g_rsv
            assign bw_sec[b]  = 1'b0;
            assign bw_priv[b] = 1'b0;
        end
        if (b == AC_BIT) begin : g_ac
            assign tc_sec[b]  = bkp_sec;
            assign tc_priv[b] = bkp_priv;
        end else begin : g_tc
            assign tc_sec[b]  = fsec[FN_TAMP];
            assign tc_priv[b] = fpriv[FN_TAMP];
        end
    end

    always_comb begin
        logic fn_s, fn_p;
        fn_s = fsec[info.fn];
        fn_p = fpriv[info.fn];

        sec_ok = '1;
        if (!sec) begin
            case (info.kind)
                RK_GROUP:   sec_ok = fn_s ? '0 : '1;
                RK_BITWISE: sec_ok = ~bw_sec;
                RK_TAMPCFG: sec_ok = ~tc_sec;
                RK_SECCTL:  sec_ok = wr ? '0 : '1;
                RK_BKP:     sec_ok = bkp_sec ? '0 : '1;
                default:    sec_ok = '1;
            endcase
        end

        whole_viol = !sec && (((info.kind == RK_GROUP) && fn_s) ||
                              ((info.kind == RK_BKP) && bkp_sec) ||
                              ((info.kind == RK_SECCTL) && wr));

        priv_ok = '1;
        if (!priv) begin
            if (info.kind == RK_BKP) begin
                priv_ok = bkp_priv ? '0 : '1;
            end else if (!gpriv) begin
                priv_ok = (!wr && info.open_rd) ? '1 : '0;
            end else begin
                case (info.kind)
                    RK_OPEN:    priv_ok = '1;
                    RK_GROUP:   priv_ok = fn_p ? '0 : '1;
                    RK_BITWISE: priv_ok = ~bw_priv;
                    RK_TAMPCFG: priv_ok = ~tc_priv;
                    RK_SECCTL,
                    RK_PRIVCTL: priv_ok = wr ? '0 : '1;
                    default:    priv_ok = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/rtc_filt_ctlregs.sv
module rtc_filt_ctlregs
    import rtc_filt_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_FUNC = 7
) (
    input  logic                clk,
    input  logic                rst_bkp_n,
    input  logic                wr_sec,
    input  logic                wr_priv,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W-1:0]   wmask,
    output logic [NUM_FUNC-1:0] fsec,
    output logic [NUM_FUNC-1:0] fpriv,
    output logic                bkp_sec,
    output logic                bkp_priv,
    output logic                gpriv,
    output logic [DATA_W-1:0]   sec_word,
    output logic [DATA_W-1:0]   priv_word
);
    typedef struct packed {
        logic [NUM_FUNC-1:0] fsec;
        logic [NUM_FUNC-1:0] fpriv;
        logic                bkp_sec;
        logic                bkp_priv;
        logic                gpriv;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        logic [DATA_W-1:0] ms, mp;
        sec_word  = '0;
        priv_word = '0;
        sec_word[NUM_FUNC-1:0]  = st_q.fsec;
        sec_word[BKP_BIT]       = st_q.bkp_sec;
        priv_word[NUM_FUNC-1:0] = st_q.fpriv;
        priv_word[BKP_BIT]      = st_q.bkp_priv;
        priv_word[GLOBAL_BIT]   = st_q.gpriv;

        ms = (sec_word & ~wmask) | (wdata & wmask);
        mp = (priv_word & ~wmask) | (wdata & wmask);

        st_d = st_q;
        if (wr_sec) begin
            st_d.fsec    = ms[NUM_FUNC-1:0];
            st_d.bkp_sec = ms[BKP_BIT];
        end
        if (wr_priv) begin
            st_d.fpriv    = mp[NUM_FUNC-1:0];
            st_d.bkp_priv = mp[BKP_BIT];
            st_d.gpriv    = mp[GLOBAL_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_bkp_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign fsec     = st_q.fsec;
    assign fpriv    = st_q.fpriv;
    assign bkp_sec  = st_q.bkp_sec;
    assign bkp_priv = st_q.bkp_priv;
    assign gpriv    = st_q.gpriv;

    // R11: protection state moves only on a control write
    p_hold_no_write_r11: assert property (@(posedge clk) disable iff (!rst_bkp_n)
        (!wr_sec && !wr_priv) |=> $stable(st_q));
endmodule

// File: rtl/rtc_access_filter.sv
module rtc_access_filter
    import rtc_filt_pkg::*;
#(
    parameter int unsigned ADDR_W   = 5,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_BKP  = 8,
    parameter int unsigned NUM_FUNC = 7
) (
    input  logic                  clk,
    input  logic                  rst_bkp_n,
    input  logic                  rst_sys_n,
    input  logic                  bus_req,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic [DATA_W/8-1:0]   bus_be,
    input  logic                  bus_sec,
    input  logic                  bus_priv,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  rf_we,
    output logic [ADDR_W-1:0]     rf_addr,
    output logic [DATA_W-1:0]     rf_wdata,
    output logic [DATA_W-1:0]     rf_wmask,
    input  logic [DATA_W-1:0]     rf_rdata,
    output logic                  illegal_pulse,
    output logic                  secure_active
);
    localparam int unsigned BE_W = DATA_W / 8;

    typedef struct packed {
        logic flag;
    } flt_t;

    reg_info_t           info;
    logic [DATA_W-1:0]   sec_ok, priv_ok, allow, be_mask, wmask;
    logic [DATA_W-1:0]   sec_word, priv_word;
    logic [NUM_FUNC-1:0] fsec, fpriv;
    logic                bkp_sec, bkp_priv, gpriv, whole_viol;
    logic                sec_wr, priv_wr;
    flt_t                f_d, f_q;

    for (genvar g = 0; g < BE_W; g++) begin : g_be
        assign be_mask[g*8 +: 8] = {8{bus_be[g]}};
    end

    rtc_filt_decode #(.ADDR_W(ADDR_W), .NUM_BKP(NUM_BKP)) u_dec (
        .addr (bus_addr),
        .info (info)
    );

    rtc_filt_perm #(.DATA_W(DATA_W), .NUM_FUNC(NUM_FUNC)) u_perm (
        .info       (info),
        .wr         (bus_we),
        .sec        (bus_sec),
        .priv       (bus_priv),
        .fsec       (fsec),
        .fpriv      (fpriv),
        .bkp_sec    (bkp_sec),
        .bkp_priv   (bkp_priv),
        .gpriv      (gpriv),
        .sec_ok     (sec_ok),
        .priv_ok    (priv_ok),
        .whole_viol (whole_viol)
    );

    rtc_filt_ctlregs #(.DATA_W(DATA_W), .NUM_FUNC(NUM_FUNC)) u_ctl (
        .clk       (clk),
        .rst_bkp_n (rst_bkp_n),
        .wr_sec    (sec_wr),
        .wr_priv   (priv_wr),
        .wdata     (bus_wdata),
        .wmask     (wmask),
        .fsec      (fsec),
        .fpriv     (fpriv),
        .bkp_sec   (bkp_sec),
        .bkp_priv  (bkp_priv),
        .gpriv     (gpriv),
        .sec_word  (sec_word),
        .priv_word (priv_word)
    );

    always_comb begin
        logic mapped, is_ctl, any_wr;
        logic [DATA_W-1:0] src;
        mapped = (info.kind != RK_NONE);
        is_ctl = (info.kind == RK_SECCTL) || (info.kind == RK_PRIVCTL);
        allow  = sec_ok & priv_ok & {DATA_W{mapped}};
        wmask  = allow & be_mask;
        any_wr = bus_req && bus_we && (|wmask);
        rf_we   = any_wr && mapped && !is_ctl;
        sec_wr  = any_wr && (info.kind == RK_SECCTL);
        priv_wr = any_wr && (info.kind == RK_PRIVCTL);
        if (info.kind == RK_SECCTL)       src = sec_word;
        else if (info.kind == RK_PRIVCTL) src = priv_word;
        else                              src = rf_rdata;
        bus_rdata = (bus_req && !bus_we) ? (src & allow) : '0;
        f_d.flag  = bus_req && whole_viol;
    end

    always_ff @(posedge clk) begin
        if (!rst_sys_n || !rst_bkp_n) f_q <= '0;
        else                          f_q <= f_d;
    end

    assign rf_addr       = bus_addr;
    assign rf_wdata      = bus_wdata;
    assign rf_wmask      = wmask;
    assign illegal_pulse = f_q.flag;
    assign secure_active = (|fsec) || bkp_sec;

    // R2: non-secure write to a secured function register never reaches the file
    p_ns_write_drop_r2: assert property (@(posedge clk) disable iff (!rst_bkp_n || !rst_sys_n)
        (bus_req && bus_we && !bus_sec && (info.kind == RK_GROUP) && fsec[info.fn]) |-> !rf_we);

    // R3: non-secure read of a secured function register reads zero
    p_ns_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_bkp_n || !rst_sys_n)
        (bus_req && !bus_we && !bus_sec && (info.kind == RK_GROUP) && fsec[info.fn]) |-> (bus_rdata == '0));

    // R4: the pulse only follows a non-secure request
    p_flag_source_r4: assert property (@(posedge clk) disable iff (!rst_bkp_n || !rst_sys_n)
        illegal_pulse |-> ($past(bus_req) && !$past(bus_sec)));

    // R8: unprivileged writes with global privilege clear touch nothing outside backup
    p_unpriv_write_r8: assert property (@(posedge clk) disable iff (!rst_bkp_n || !rst_sys_n)
        (bus_req && bus_we && !bus_priv && !gpriv && (info.kind != RK_BKP)) |-> (!rf_we && !sec_wr && !priv_wr));

    // R1: non-secure writes leave the secure word unchanged
    p_secword_guard_r1: assert property (@(posedge clk) disable iff (!rst_bkp_n || !rst_sys_n)
        (bus_req && bus_we && !bus_sec && (info.kind == RK_SECCTL)) |=> $stable(sec_word));

    // R12: setting the init secure bit makes the block secure-active
    p_secure_active_r12: assert property (@(posedge clk) disable iff (!rst_bkp_n || !rst_sys_n)
        (bus_req && bus_we && bus_sec && bus_priv && (info.kind == RK_SECCTL) && bus_be[0] && bus_wdata[0]) |=> secure_active);
endmodule

// File: tb/sim_rtc_access_filter.sv
module sim_rtc_access_filter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_bkp_n, rst_sys_n;
    logic        bus_req, bus_we, bus_sec, bus_priv;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata, rf_rdata;
    logic [3:0]  bus_be;
    logic [31:0] bus_rdata, rf_wdata, rf_wmask;
    logic [4:0]  rf_addr;
    logic        rf_we, illegal_pulse, secure_active;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] m_sec  = '0;
    logic [31:0] m_priv = '0;
    logic [31:0] rfv    = 32'hFFFF_FFFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_access_filter u0 (
        .clk(clk), .rst_bkp_n(rst_bkp_n), .rst_sys_n(rst_sys_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_sec(bus_sec),
        .bus_priv(bus_priv), .bus_rdata(bus_rdata), .rf_we(rf_we),
        .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_wmask(rf_wmask),
        .rf_rdata(rf_rdata), .illegal_pulse(illegal_pulse),
        .secure_active(secure_active)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // owner of bit i of register a: -1 none, 0..6 function, 7 backup
    function automatic int owner(input int a, input int i);
        case (a)
            0, 1, 3, 5: return 0;
            4:          return 1;
            9:          return 2;
            6:          return 3;
            7:          return 4;
            8:          return 5;
            10:         return (i == 31) ? 7 : 6;
            11, 12, 13: return (i < 7) ? i : -1;
            default:    return (a >= 16 && a < 24) ? 7 : -1;
        endcase
    endfunction

    function automatic bit prot(input int own, input logic [31:0] w);
        if (own < 0) return 1'b0;
        if (own == 7) return w[8];
        return w[own];
    endfunction

    function automatic logic [31:0] ref_allow(input int a, input bit wr, input bit s, input bit p);
        logic [31:0] r;
        bit bkp, openrd;
        r = '0;
        if (a >= 24) return r;
        bkp    = (a >= 16);
        openrd = (a <= 4) || (a == 14) || (a == 15);
        for (int i = 0; i < 32; i++) begin
            bit sb, pb;
            sb = !s && (((a == 14) && wr) || prot(owner(a, i), m_sec));
            if (p)              pb = 1'b0;
            else if (bkp)       pb = m_priv[8];
            else if (!m_priv[15]) pb = wr || !openrd;
            else                pb = (((a == 14) || (a == 15)) && wr) || prot(owner(a, i), m_priv);
            r[i] = !sb && !pb;
        end
        return r;
    endfunction

    function automatic bit ref_whole(input int a, input bit wr, input bit s);
        if (s) return 1'b0;
        if (a == 14 && wr) return 1'b1;
        if (a <= 9 && a != 2) return m_sec[owner(a, 0)];
        if (a >= 16 && a < 24) return m_sec[8];
        return 1'b0;
    endfunction

    task automatic acc(input string tag, input bit wr, input int a, input logic [31:0] wd,
                       input logic [3:0] be, input bit s, input bit p);
        logic [31:0] al, bem, wm, src, exp_rd;
        bit exp_we, exp_flag;
        @(negedge clk);
        bus_req = 1'b1; bus_we = wr; bus_addr = 5'(a); bus_wdata = wd;
        bus_be = be; bus_sec = s; bus_priv = p; rf_rdata = rfv;
        #1;
        al  = ref_allow(a, wr, s, p);
        bem = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
        wm  = al & bem;
        exp_we = wr && (a < 24) && (a != 14) && (a != 15) && (wm != 0);
        if (a == 14)      src = m_sec;
        else if (a == 15) src = m_priv;
        else              src = rfv;
        exp_rd = wr ? 32'h0 : (src & al);
        exp_flag = ref_whole(a, wr, s);
        chk({tag, " rf_we"}, 32'(rf_we), 32'(exp_we));
        if (exp_we) chk({tag, " rf_wmask"}, rf_wmask, wm);
        chk({tag, " rdata"}, bus_rdata, exp_rd);
        @(posedge clk);
        if (wr && wm != 0 && a == 14) m_sec  = ((m_sec  & ~wm) | (wd & wm)) & 32'h0000_017F;
        if (wr && wm != 0 && a == 15) m_priv = ((m_priv & ~wm) | (wd & wm)) & 32'h0000_817F;
        @(negedge clk);
        bus_req = 1'b0;
        #1;
        chk({tag, " illegal_pulse"}, 32'(illegal_pulse), 32'(exp_flag));
        chk({tag, " secure_active"}, 32'(secure_active), 32'((m_sec & 32'h17F) != 0));
    endtask

    task automatic rd(input string tag, input int a, input bit s, input bit p);
        acc(tag, 1'b0, a, 32'h0, 4'hF, s, p);
    endtask

    task automatic wr(input string tag, input int a, input logic [31:0] d, input bit s, input bit p);
        acc(tag, 1'b1, a, d, 4'hF, s, p);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bus_req = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; bus_be = 0;
        bus_sec = 0; bus_priv = 0; rf_rdata = 0;
        rst_bkp_n = 0; rst_sys_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_bkp_n = 1; rst_sys_n = 1;
        #1;
        chk("R1 reset illegal_pulse", 32'(illegal_pulse), 32'h0);
        chk("R1 reset secure_active", 32'(secure_active), 32'h0);

        // R1: open state after backup reset
        rd("R1 secure word zero", 14, 1, 1);
        wr("R1 secure write time", 0, 32'h1234_5678, 1, 1);
        wr("R1 nonsecure write time", 0, 32'h1234_5678, 0, 1);
        rd("R1 nonsecure read date", 1, 0, 1);
        wr("R1 R4 nonsecure write secure word", 14, 32'h0000_017F, 0, 1);
        rd("R1 secure word still zero", 14, 0, 1);

        // R12: secure the init function
        wr("R12 set init secure", 14, 32'h0000_0001, 1, 1);
        wr("R2 R4 nonsecure write time", 0, 32'hDEAD_BEEF, 0, 1);
        rd("R3 R4 nonsecure read time", 0, 0, 1);
        rd("R3 nonsecure read control", 5, 0, 1);
        wr("R2 secure write time", 0, 32'hDEAD_BEEF, 1, 1);
        rd("R13 nonsecure read subsecond", 2, 0, 1);
        rd("R13 nonsecure read wakeup", 6, 0, 1);

        // R5: bit-wise words
        wr("R5 nonsecure write status", 11, 32'hFFFF_FFFF, 0, 1);
        rd("R5 nonsecure read flagclr", 12, 0, 1);
        wr("R5 secure set wake and alarm1", 14, 32'h0000_0029, 1, 1);
        wr("R5 nonsecure write maskstat", 13, 32'hFFFF_FFFF, 0, 1);

        // R6: tamper word
        wr("R6 secure tamper only", 14, 32'h0000_0040, 1, 1);
        wr("R6 nonsecure write tampcfg", 10, 32'hFFFF_FFFF, 0, 1);
        rd("R6 nonsecure read tampcfg", 10, 0, 1);
        wr("R6 secure backup only", 14, 32'h0000_0100, 1, 1);
        wr("R6 nonsecure write tampcfg ac", 10, 32'hFFFF_FFFF, 0, 1);
        wr("R6 secure both", 14, 32'h0000_0140, 1, 1);
        wr("R6 nonsecure tampcfg all blocked", 10, 32'hFFFF_FFFF, 0, 1);

        // R10: backup secure
        rd("R10 R4 nonsecure read backup", 16, 0, 1);
        wr("R10 R4 nonsecure write backup", 23, 32'h5555_AAAA, 0, 1);
        rd("R10 secure read backup", 17, 1, 1);
        rd("R13 unmapped read", 24, 1, 1);
        wr("R13 unmapped write", 30, 32'hFFFF_FFFF, 1, 1);

        // R11: system reset keeps settings
        wr("R11 setup init secure", 14, 32'h0000_0001, 1, 1);
        @(negedge clk); rst_sys_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_sys_n = 1;
        #1;
        chk("R11 secure_active kept", 32'(secure_active), 32'h1);
        chk("R11 pulse cleared", 32'(illegal_pulse), 32'h0);
        rd("R11 secure word kept", 14, 1, 1);
        rd("R11 R3 time still protected", 0, 0, 1);

        // backup reset clears protection
        @(negedge clk); rst_bkp_n = 0;
        @(posedge clk);
        @(negedge clk); rst_bkp_n = 1;
        m_sec = '0; m_priv = '0;
        #1;
        chk("R1 backup reset secure_active", 32'(secure_active), 32'h0);

        // R7 R8: global privilege clear
        rfv = 32'hA5C3_0F96;
        rd("R7 unpriv read calib", 4, 0, 0);
        rd("R7 unpriv read wakeup", 6, 0, 0);
        rd("R7 unpriv read privilege word", 15, 0, 0);
        rd("R7 unpriv read status", 11, 1, 0);
        wr("R8 unpriv write time", 0, 32'h1, 1, 0);
        wr("R8 unpriv write privilege word", 15, 32'h0000_8008, 1, 0);
        wr("R10 unpriv write backup open", 18, 32'h0F0F_0F0F, 0, 0);
        wr("R10 set backup privilege", 15, 32'h0000_0100, 1, 1);
        wr("R10 unpriv write backup blocked", 18, 32'h0F0F_0F0F, 0, 0);
        rd("R10 priv read backup", 18, 0, 1);

        // R9: per-function privilege
        wr("R9 global on wake priv", 15, 32'h0000_8008, 1, 1);
        wr("R9 unpriv write wakeup", 6, 32'hFFFF_FFFF, 1, 0);
        wr("R9 unpriv write alarm0", 7, 32'hFFFF_FFFF, 1, 0);
        rd("R9 unpriv read status", 11, 1, 0);
        wr("R9 unpriv write secure word", 14, 32'h1, 1, 0);
        wr("R9 unpriv write backup open", 20, 32'h1, 1, 0);

        // R14: byte enables
        acc("R14 secword byte0 only", 1'b1, 14, 32'hFFFF_FF05, 4'b0001, 1, 1);
        rd("R14 secword readback", 14, 1, 1);
        acc("R14 rf upper half", 1'b1, 2, 32'hCAFE_F00D, 4'b1100, 1, 1);
        acc("R14 privword byte1", 1'b1, 15, 32'h0000_0000, 4'b0010, 1, 1);
        rd("R14 privword readback", 15, 1, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule